// File: doc/BRIEF.md
# Power-Management Event Register Window with SCI Generation

This block gives software a small relocatable I/O window holding a PM1 event status register, a PM1 event enable register, a PM1 control register and a free-running power-management timer. A byte-wide configuration port holds the window base and an enable bit. The block merges four latched event sources with an external general-purpose-event request into a system control interrupt (SCI).

An APM command port carries ACPI on/off commands that set or clear the SCI-enable bit in the control register. Each APM command can also raise a system management interrupt (SMI) pulse when a configuration bit allows it.

Two small state machines shape the timing. The read responder has states RD_IDLE and RD_RESP. It moves RD_IDLE→RD_RESP on a read strobe, stays in RD_RESP on a back-to-back strobe, and returns to RD_IDLE otherwise. The SMI generator has states SMI_IDLE and SMI_FIRE. It moves SMI_IDLE→SMI_FIRE on an APM write that the gate bit allows, stays in SMI_FIRE for another allowed write, and returns to SMI_IDLE otherwise.

Top module: `pm1_evt_ctl`

## Requirements
- R1: After reset, configuration byte 0x40 reads 0x01. Bytes 0x41 to 0x43, 0x58 to 0x5B and 0x80 read 0x00.
- R2: The window base is bits 15:6 of the configuration dword at 0x40 (value masked with 0xFFC0), and bit 0 of byte 0x40 always reads 1. The window spans 64 bytes and is decoded only while bit 0 of configuration byte 0x80 is 1. A read that misses the window returns 0.
- R3: Window offset 0x00 selects status, 0x02 enable, 0x04 control and 0x08 the timer. Every other offset reads 0 and ignores writes. io_rvalid is high, with io_rdata, exactly one cycle after each io_rd cycle, and the data reflects register state before that edge.
- R4: Status holds only bit 0 (timer), bit 5 (global lock), bit 8 (power button) and bit 10 (real-time clock); all other bits read 0. Writing 1 to a status bit clears it. An event arriving in the same cycle as its clear wins.
- R5: A pwrbtn_req cycle sets status bit 8 at the next clock edge, and sci reflects it from that same edge.
- R6: sci is 1 whenever status AND enable is non-zero in bits 0, 5, 8 or 10, or whenever gpe_req is 1. A status bit whose enable bit is 0 does not raise sci.
- R7: The timer counts up by one on each edge with tmr_tick high and holds otherwise. It reads as the count zero-extended to 32 bits.
- R8: When a tick flips the timer's top bit, status bit 0 is set at that edge.
- R9: An APM write of 0xF1 sets control bit 0, and an APM write of 0xF0 clears it. Other values leave it unchanged, and an APM write overrides an I/O write to control in the same cycle.
- R10: While bit 1 of configuration byte 0x5B is 1, each APM write drives smi high for the following cycle. Otherwise smi stays 0.
- R11: I/O writes made while the window is disabled change no register.
- R12: Configuration bytes other than 0x40 to 0x43, 0x58 to 0x5B and 0x80 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 32 | I/O read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read response strobe |
| tmr_tick | input | 1 | Timer increment enable |
| pwrbtn_req | input | 1 | Power-button event pulse |
| rtc_evt | input | 1 | Real-time-clock event pulse |
| glock_evt | input | 1 | Global-lock event pulse |
| gpe_req | input | 1 | General-purpose event request level |
| apm_wr | input | 1 | APM command write strobe |
| apm_data | input | 8 | APM command value |
| sci | output | 1 | System control interrupt level |
| smi | output | 1 | System management interrupt pulse |

## Verification
The assertions assume that inputs are zero throughout reset. They also assume that the enable register changes only through in-window I/O writes, and that an APM write never carries both 0xF1 and 0xF0. The stimulus drives every strobe for exactly one cycle, away from the clock edge, and holds gpe_req and tmr_tick low except in the phases that test them. The timer is instantiated narrow so that a top-bit flip is reached in a few hundred ticks. No read is issued in a cycle that also writes or ticks, so each queued expected value is fixed when it is pushed.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    localparam int CFG_AW  = 8;
    localparam int IO_AW   = 16;
    localparam int REG_W   = 16;
    localparam int DATA_W  = 32;

    // configuration space layout
    localparam logic [CFG_AW-1:0] CFG_BASE0 = 8'h40;
    localparam logic [CFG_AW-1:0] CFG_MISC0 = 8'h58;
    localparam logic [CFG_AW-1:0] CFG_WINEN = 8'h80;
    localparam int SMI_GATE_BIT = 8 * 3 + 1;   // byte 0x5B, bit 1

    // window offsets
    localparam logic [7:0] OFS_STS = 8'h00;
    localparam logic [7:0] OFS_EN  = 8'h02;
    localparam logic [7:0] OFS_CTL = 8'h04;
    localparam logic [7:0] OFS_TMR = 8'h08;

    // event bit positions
    localparam int B_TMR = 0;
    localparam int B_GLK = 5;
    localparam int B_PWR = 8;
    localparam int B_RTC = 10;
    localparam logic [REG_W-1:0] SCI_SRC_MASK = 16'h0521;

    localparam logic [7:0] APM_ACPI_ON  = 8'hF1;
    localparam logic [7:0] APM_ACPI_OFF = 8'hF0;

    typedef enum logic { RD_IDLE, RD_RESP } rd_state_e;
    typedef enum logic { SMI_IDLE, SMI_FIRE } smi_state_e;
endpackage

// File: rtl/pmx_cfg_space.sv
module pmx_cfg_space
    import pmx_pkg::*;
#(
    parameter int WIN_BITS = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [7:0]                cfg_wdata,
    output logic [7:0]                cfg_rdata,
    output logic [IO_AW-WIN_BITS-1:0] win_tag,
    output logic                      win_on,
    output logic                      smi_gate
);
    localparam int NBYTE = 4;

    logic [8*NBYTE-1:0] base_q;
    logic [8*NBYTE-1:0] misc_q;
    logic [7:0]         winen_q;

    logic in_base, in_misc, in_winen;
    assign in_base  = (cfg_addr[CFG_AW-1:2] == CFG_BASE0[CFG_AW-1:2]);
    assign in_misc  = (cfg_addr[CFG_AW-1:2] == CFG_MISC0[CFG_AW-1:2]);
    assign in_winen = (cfg_addr == CFG_WINEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= {{(8*NBYTE-1){1'b0}}, 1'b1};
            misc_q  <= '0;
            winen_q <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NBYTE; i++) begin
                if (cfg_addr[1:0] == 2'(i)) begin
                    if (in_base)
                        base_q[8*i +: 8] <= cfg_wdata | ((i == 0) ? 8'h01 : 8'h00);
                    if (in_misc)
                        misc_q[8*i +: 8] <= cfg_wdata;
                end
            end
            if (in_winen)
                winen_q <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (in_base)
            cfg_rdata = base_q[8*cfg_addr[1:0] +: 8];
        else if (in_misc)
            cfg_rdata = misc_q[8*cfg_addr[1:0] +: 8];
        else if (in_winen)
            cfg_rdata = winen_q;
    end

    assign win_tag  = base_q[IO_AW-1:WIN_BITS];
    assign win_on   = winen_q[0];
    assign smi_gate = misc_q[SMI_GATE_BIT];
endmodule

// File: rtl/pmx_pm_timer.sv
module pmx_pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [TMR_W-1:0] cnt_q,
    output logic             msb_flip
);
    // the top bit changes exactly when all lower bits are ones and a tick arrives
    assign msb_flip = tick && (&cnt_q[TMR_W-2:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pmx_apm_ctl.sv
module pmx_apm_ctl
    import pmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apm_wr,
    input  logic [7:0] apm_data,
    input  logic       smi_gate,
    output logic       acpi_on,
    output logic       acpi_off,
    output logic       smi
);
    smi_state_e state_q, state_d;
    logic fire;

    assign fire     = apm_wr && smi_gate;
    assign acpi_on  = apm_wr && (apm_data == APM_ACPI_ON);
    assign acpi_off = apm_wr && (apm_data == APM_ACPI_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SMI_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMI_IDLE: state_d = fire ? SMI_FIRE : SMI_IDLE;
            SMI_FIRE: state_d = fire ? SMI_FIRE : SMI_IDLE;
            default:  state_d = SMI_IDLE;
        endcase
    end

    always_comb begin
        smi = 1'b0;
        unique case (state_q)
            SMI_IDLE: smi = 1'b0;
            SMI_FIRE: smi = 1'b1;
            default:  smi = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmx_pm1_regs.sv
module pmx_pm1_regs
    import pmx_pkg::*;
#(
    parameter int WIN_BITS = 6,
    parameter int TMR_W    = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IO_AW-1:0]          io_addr,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic [REG_W-1:0]          io_wdata,
    output logic [DATA_W-1:0]         io_rdata,
    output logic                      io_rvalid,
    input  logic [IO_AW-WIN_BITS-1:0] win_tag,
    input  logic                      win_on,
    input  logic                      ev_tmr,
    input  logic                      ev_glk,
    input  logic                      ev_pwr,
    input  logic                      ev_rtc,
    input  logic                      acpi_on,
    input  logic                      acpi_off,
    input  logic                      gpe_req,
    input  logic [TMR_W-1:0]          tmr_cnt,
    output logic                      sci
);
    logic [REG_W-1:0] sts_q, sts_d;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] ctl_q, ctl_d;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    rd_state_e rd_state_q, rd_state_d;

    logic hit;
    logic [WIN_BITS-1:0] ofs;
    logic wr_sts, wr_en, wr_ctl;

    assign hit    = win_on && (io_addr[IO_AW-1:WIN_BITS] == win_tag);
    assign ofs    = io_addr[WIN_BITS-1:0];
    assign wr_sts = io_wr && hit && (ofs == WIN_BITS'(OFS_STS));
    assign wr_en  = io_wr && hit && (ofs == WIN_BITS'(OFS_EN));
    assign wr_ctl = io_wr && hit && (ofs == WIN_BITS'(OFS_CTL));

    // status: events set, ones written clear, set wins
    always_comb begin
        logic [REG_W-1:0] set_v, clr_v;
        set_v        = '0;
        set_v[B_TMR] = ev_tmr;
        set_v[B_GLK] = ev_glk;
        set_v[B_PWR] = ev_pwr;
        set_v[B_RTC] = ev_rtc;
        clr_v        = wr_sts ? io_wdata : '0;
        sts_d        = ((sts_q & ~clr_v) | set_v) & SCI_SRC_MASK;
    end

    // control: APM commands take priority over an I/O write
    always_comb begin
        ctl_d = wr_ctl ? io_wdata : ctl_q;
        if (acpi_on)
            ctl_d[0] = 1'b1;
        else if (acpi_off)
            ctl_d[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            sts_q <= sts_d;
            ctl_q <= ctl_d;
            if (wr_en)
                en_q <= io_wdata;
        end
    end

    assign sci = (|(sts_q & en_q & SCI_SRC_MASK)) || gpe_req;

    // read data selection
    always_comb begin
        rd_mux = '0;
        if (hit) begin
            if (ofs == WIN_BITS'(OFS_STS))
                rd_mux = DATA_W'(sts_q);
            else if (ofs == WIN_BITS'(OFS_EN))
                rd_mux = DATA_W'(en_q);
            else if (ofs == WIN_BITS'(OFS_CTL))
                rd_mux = DATA_W'(ctl_q);
            else if (ofs == WIN_BITS'(OFS_TMR))
                rd_mux = DATA_W'(tmr_cnt);
        end
    end

    // read response state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_state_q <= RD_IDLE;
        else
            rd_state_q <= rd_state_d;
    end

    always_comb begin
        rd_state_d = rd_state_q;
        unique case (rd_state_q)
            RD_IDLE: rd_state_d = io_rd ? RD_RESP : RD_IDLE;
            RD_RESP: rd_state_d = io_rd ? RD_RESP : RD_IDLE;
            default: rd_state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= io_rd ? rd_mux : '0;
    end

    always_comb begin
        io_rvalid = 1'b0;
        unique case (rd_state_q)
            RD_IDLE: io_rvalid = 1'b0;
            RD_RESP: io_rvalid = 1'b1;
            default: io_rvalid = 1'b0;
        endcase
    end

    assign io_rdata = rdata_q;
endmodule

// File: rtl/pm1_evt_ctl.sv
module pm1_evt_ctl
    import pmx_pkg::*;
#(
    parameter int WIN_BITS = 6,
    parameter int TMR_W    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [15:0]       io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [15:0]       io_wdata,
    output logic [31:0]       io_rdata,
    output logic              io_rvalid,
    input  logic              tmr_tick,
    input  logic              pwrbtn_req,
    input  logic              rtc_evt,
    input  logic              glock_evt,
    input  logic              gpe_req,
    input  logic              apm_wr,
    input  logic [7:0]        apm_data,
    output logic              sci,
    output logic              smi
);
    logic [IO_AW-WIN_BITS-1:0] win_tag;
    logic win_on, smi_gate;
    logic acpi_on, acpi_off;
    logic [TMR_W-1:0] tmr_cnt;
    logic tmr_flip;

    pmx_cfg_space #(.WIN_BITS(WIN_BITS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .win_tag(win_tag), .win_on(win_on), .smi_gate(smi_gate)
    );

    pmx_pm_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .tick(tmr_tick), .cnt_q(tmr_cnt), .msb_flip(tmr_flip)
    );

    pmx_apm_ctl u_apm (
        .clk(clk), .rst_n(rst_n),
        .apm_wr(apm_wr), .apm_data(apm_data), .smi_gate(smi_gate),
        .acpi_on(acpi_on), .acpi_off(acpi_off), .smi(smi)
    );

    pmx_pm1_regs #(.WIN_BITS(WIN_BITS), .TMR_W(TMR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .win_tag(win_tag), .win_on(win_on),
        .ev_tmr(tmr_flip), .ev_glk(glock_evt), .ev_pwr(pwrbtn_req), .ev_rtc(rtc_evt),
        .acpi_on(acpi_on), .acpi_off(acpi_off), .gpe_req(gpe_req),
        .tmr_cnt(tmr_cnt), .sci(sci)
    );
endmodule

// File: rtl/pm1_evt_chk.sv
module pm1_evt_chk
    import pmx_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_rd,
    input logic             io_wr,
    input logic             io_rvalid,
    input logic             pwrbtn_req,
    input logic             gpe_req,
    input logic             sci,
    input logic             tmr_tick,
    input logic [TMR_W-1:0] tmr,
    input logic             apm_wr,
    input logic [7:0]       apm_data,
    input logic             smi_gate,
    input logic             smi,
    input logic             win_on,
    input logic [15:0]      sts,
    input logic [15:0]      en,
    input logic             ctl0
);
    a_r3_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> io_rvalid);
    a_r3_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> !io_rvalid);
    a_r5_pwrbtn_latch: assert property (@(posedge clk) disable iff (!rst_n)
        pwrbtn_req |=> sts[B_PWR]);
    a_r6_gpe_sci: assert property (@(posedge clk) disable iff (!rst_n)
        gpe_req |-> sci);
    a_r7_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_tick |=> tmr == TMR_W'($past(tmr) + 1'b1));
    a_r7_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_tick |=> $stable(tmr));
    a_r9_acpi_on: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == APM_ACPI_ON) |=> ctl0);
    a_r9_acpi_off: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == APM_ACPI_OFF) |=> !ctl0);
    a_r10_smi_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && smi_gate) |=> smi);
    a_r10_smi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !apm_wr |=> !smi);
    a_r11_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_on && io_wr) |=> $stable(en));
endmodule

bind pm1_evt_ctl pm1_evt_chk #(.TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .io_rd(io_rd), .io_wr(io_wr), .io_rvalid(io_rvalid),
    .pwrbtn_req(pwrbtn_req), .gpe_req(gpe_req), .sci(sci),
    .tmr_tick(tmr_tick), .tmr(tmr_cnt),
    .apm_wr(apm_wr), .apm_data(apm_data), .smi_gate(smi_gate), .smi(smi),
    .win_on(win_on),
    .sts(u_regs.sts_q), .en(u_regs.en_q), .ctl0(u_regs.ctl_q[0])
);

// File: tb/pm1_evt_ctl_tb.sv
module pm1_evt_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_we; logic [7:0] cfg_addr, cfg_wdata, cfg_rdata;
    logic [15:0] io_addr, io_wdata; logic io_wr, io_rd;
    logic [31:0] io_rdata; logic io_rvalid;
    logic tmr_tick, pwrbtn_req, rtc_evt, glock_evt, gpe_req, apm_wr;
    logic [7:0] apm_data;
    logic sci, smi;

    int n_tests = 0;
    int n_fail = 0;
    int tmr_exp = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pm1_evt_ctl #(.WIN_BITS(6), .TMR_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .tmr_tick(tmr_tick), .pwrbtn_req(pwrbtn_req), .rtc_evt(rtc_evt),
        .glock_evt(glock_evt), .gpe_req(gpe_req),
        .apm_wr(apm_wr), .apm_data(apm_data), .sci(sci), .smi(smi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every read response
    always @(negedge clk) begin
        if (rst_n && io_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected response", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, io_rdata, e);
            end
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input logic [7:0] a, input logic [7:0] e, input string req);
        @(negedge clk); cfg_addr = a;
        #1 check(req, {24'd0, cfg_rdata}, {24'd0, e});
    endtask

    task automatic io_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, input logic [31:0] e, input string req);
        @(negedge clk); io_rd = 1'b1; io_addr = a;
        exp_q.push_back(e); tag_q.push_back(req);
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic apm_cmd(input logic [7:0] d, input logic gate);
        @(negedge clk); apm_wr = 1'b1; apm_data = d;
        @(negedge clk); apm_wr = 1'b0;
        #1 check("R10 smi after APM write", {31'd0, smi}, {31'd0, gate});
        @(negedge clk);
        #1 check("R10 smi returns low", {31'd0, smi}, 32'd0);
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tmr_tick = 1'b1;
        repeat (n) @(negedge clk);
        tmr_tick = 1'b0;
        tmr_exp += n;
    endtask

    task automatic pulse_evt(input int which);
        @(negedge clk);
        case (which)
            0: pwrbtn_req = 1'b1;
            1: rtc_evt = 1'b1;
            default: glock_evt = 1'b1;
        endcase
        @(negedge clk);
        pwrbtn_req = 1'b0; rtc_evt = 1'b0; glock_evt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        io_addr = 0; io_wdata = 0; io_wr = 0; io_rd = 0;
        tmr_tick = 0; pwrbtn_req = 0; rtc_evt = 0; glock_evt = 0; gpe_req = 0;
        apm_wr = 0; apm_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cfg_check(8'h40, 8'h01, "R1 byte 0x40");
        cfg_check(8'h41, 8'h00, "R1 byte 0x41");
        cfg_check(8'h58, 8'h00, "R1 byte 0x58");
        cfg_check(8'h5B, 8'h00, "R1 byte 0x5B");
        cfg_check(8'h80, 8'h00, "R1 byte 0x80");
        check("R6 sci after reset", {31'd0, sci}, 32'd0);
        check("R10 smi after reset", {31'd0, smi}, 32'd0);

        // R12 unimplemented config byte
        cfg_write(8'h20, 8'h77);
        cfg_check(8'h20, 8'h00, "R12 unimplemented byte");
        cfg_write(8'h59, 8'hAA);
        cfg_check(8'h59, 8'hAA, "R1 byte 0x59 writable");

        // R2 base programming: 0x1234 masks to 0x1200
        cfg_write(8'h40, 8'h34);
        cfg_write(8'h41, 8'h12);
        cfg_check(8'h40, 8'h35, "R2 bit0 of byte 0x40 reads 1");

        // R11 window still closed
        io_write(16'h1202, 16'h0100);
        io_read(16'h1202, 32'd0, "R2 closed window reads 0");
        cfg_write(8'h80, 8'h01);
        io_read(16'h1202, 32'd0, "R11 write while closed ignored");

        // R2 window extent
        io_write(16'h1202, 16'h0520);
        io_read(16'h1202, 32'h0520, "R3 enable register readback");
        io_read(16'h1242, 32'd0, "R2 address above window misses");
        io_read(16'h11C2, 32'd0, "R2 address below window misses");

        // R3 other offsets
        io_read(16'h1204, 32'd0, "R3 control after reset");
        io_write(16'h1206, 16'hFFFF);
        io_read(16'h1206, 32'd0, "R3 unused offset reads 0");
        io_read(16'h123C, 32'd0, "R3 high offset reads 0");

        // R5 power button
        @(negedge clk);
        check("R6 sci idle", {31'd0, sci}, 32'd0);
        pulse_evt(0);
        #1 check("R5 sci after power button", {31'd0, sci}, 32'd1);
        io_read(16'h1200, 32'h0100, "R5 status bit 8 set");

        // R4 write-one-to-clear
        io_write(16'h1200, 16'h0100);
        #1 check("R4 sci after clear", {31'd0, sci}, 32'd0);
        io_read(16'h1200, 32'd0, "R4 status cleared");

        // R6 general-purpose request
        @(negedge clk); gpe_req = 1'b1;
        #1 check("R6 gpe raises sci", {31'd0, sci}, 32'd1);
        @(negedge clk); gpe_req = 1'b0;
        #1 check("R6 gpe release", {31'd0, sci}, 32'd0);

        // R6 real-time clock
        pulse_evt(1);
        #1 check("R6 rtc raises sci", {31'd0, sci}, 32'd1);
        io_read(16'h1200, 32'h0400, "R4 rtc status bit 10");
        io_write(16'h1200, 16'h0400);

        // R6 masked global lock
        io_write(16'h1202, 16'h0100);
        pulse_evt(2);
        #1 check("R6 masked glock keeps sci low", {31'd0, sci}, 32'd0);
        io_read(16'h1200, 32'h0020, "R4 glock status bit 5");
        io_write(16'h1200, 16'h0020);
        io_read(16'h1200, 32'd0, "R4 glock cleared");

        // R4 set wins over clear in the same cycle
        @(negedge clk);
        io_wr = 1'b1; io_addr = 16'h1200; io_wdata = 16'h0100; pwrbtn_req = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; pwrbtn_req = 1'b0;
        io_read(16'h1200, 32'h0100, "R4 set wins over clear");
        io_write(16'h1200, 16'hFFFF);
        io_read(16'h1200, 32'd0, "R4 all cleared");

        // R7 timer
        ticks(5);
        io_read(16'h1208, 32'(tmr_exp), "R7 timer count");

        // R8 top-bit flip
        io_write(16'h1202, 16'h0001);
        ticks((1 << (TW - 1)) - 1 - tmr_exp);
        #1 check("R8 no flag before flip", {31'd0, sci}, 32'd0);
        ticks(1);
        #1 check("R8 flip raises sci", {31'd0, sci}, 32'd1);
        io_read(16'h1200, 32'h0001, "R8 timer status bit 0");
        io_read(16'h1208, 32'(tmr_exp), "R7 zero-extended timer read");
        io_write(16'h1200, 16'h0001);

        // R9 APM commands (SMI gate off)
        apm_cmd(8'hF1, 1'b0);
        io_read(16'h1204, 32'h0001, "R9 ACPI on sets bit 0");
        apm_cmd(8'h55, 1'b0);
        io_read(16'h1204, 32'h0001, "R9 other value keeps bit 0");
        apm_cmd(8'hF0, 1'b0);
        io_read(16'h1204, 32'd0, "R9 ACPI off clears bit 0");

        // R10 SMI gate
        cfg_write(8'h5B, 8'h02);
        cfg_check(8'h5B, 8'h02, "R10 gate byte readback");
        apm_cmd(8'h33, 1'b1);
        io_read(16'h1204, 32'd0, "R9 non-command keeps control");

        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule